// File: doc/BRIEF.md
# Display Memory Contention Wait Generator

This block tracks CPU T-states from the start of each video frame. It reproduces the way a raster fetch engine takes the shared video RAM away from the CPU. The counter is cleared by a frame-start pulse. It then advances once per T-state clock enable, walking through lines of fixed length.

While the beam is inside the picture window, the block works in repeating groups of eight T-states. In each group it stalls the CPU with an active-low wait. It also issues two display-byte fetches and two attribute-byte fetches, in a fixed order, each with its 13-bit video address. Outside the window the wait stays released and no fetch is issued.

All outputs are registered and always describe the T-state the counter currently holds. A CPU model or bus arbiter can therefore use them directly as the stall and fetch pattern of that T-state.

Top module: `ctg_contention_gen`

## Requirements
- R1: After reset, wait_n and rd_n are 1, fetch_attr is 0 and vaddr is 0. The position is T-state 0 of line 0.
- R2: A frame_start pulse sampled on a clock edge returns the position to T-state 0 of line 0 on that edge, whatever tstate_en is. All outputs are idle in the next cycle.
- R3: Each line holds LINE_TSTATES T-states and each frame holds FRAME_LINES lines. After the last T-state of the frame the position wraps to T-state 0 of line 0.
- R4: The picture window covers lines from CONTEND_START/LINE_TSTATES up to, but not including, that value plus PICTURE_LINES, in T-states 0 to ACTIVE_TSTATES-1 of each line. Outside the window, wait_n and rd_n are 1, fetch_attr is 0 and vaddr is 0.
- R5: Inside the window, let the phase be the T-state index modulo 8. wait_n is 1 in phases 4 and 5 and 0 in phases 0, 1, 2, 3, 6 and 7.
- R6: Inside the window, rd_n is 0 in phases 0 to 3 and 1 in phases 4 to 7.
- R7: The fetch order within a group is: display, attribute, display, attribute. fetch_attr is 1 in phases 1 and 3 and 0 in phases 0 and 2.
- R8: For a display fetch, vaddr is {y[7:6], y[2:0], y[5:3], c}. Here y is the picture row (line minus the first window line) and c is the 5-bit column, (T-state/8)*2 + phase[1].
- R9: For an attribute fetch, vaddr is {3'b110, y[7:6], y[5:3], c}, with y and c defined as in R8.
- R10: In a cycle with tstate_en low and frame_start low, the position and all outputs hold their values.
- R11: The first stalled T-state lies exactly CONTEND_START T-states after the frame start. The T-state just before it is not stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tstate_en | input | 1 | Advance by one T-state on this edge |
| frame_start | input | 1 | Synchronous frame-origin pulse |
| wait_n | output | 1 | Active-low CPU stall |
| rd_n | output | 1 | Active-low video read strobe |
| vaddr | output | 13 | Video RAM byte address |
| fetch_attr | output | 1 | 1 = attribute fetch, 0 = display fetch |

## Verification
The bench builds the block with FRAME_LINES = 200 and CONTEND_START = 896, which gives four top-border lines; line length, active width and row count keep their defaults. With a frame of 44,800 T-states, a whole frame can be compared against an arithmetic model at every T-state. This covers all 192 picture rows, both fetch kinds and every column, the first and last picture lines, and the border lines on both sides. The run also goes past the frame wrap, issues a frame-start pulse in mid line, and finishes with a stretch of sparse enables to exercise the hold behaviour.

// File: rtl/ctg_pkg.sv
package ctg_pkg;

  localparam int VADDR_W = 13;
  localparam int ROW_W   = 8;
  localparam int COL_W   = 5;
  localparam int PHASE_W = 3;

  typedef struct packed {
    logic               wait_n;
    logic               rd_n;
    logic               is_attr;
    logic [VADDR_W-1:0] addr;
  } ctg_out_t;

  localparam ctg_out_t CTG_IDLE = '{wait_n: 1'b1, rd_n: 1'b1, is_attr: 1'b0, addr: '0};

  // Display byte: row high pair, row within cell, cell row, column.
  function automatic logic [VADDR_W-1:0] pix_addr(input logic [ROW_W-1:0] y,
                                                  input logic [COL_W-1:0] c);
    return {y[7:6], y[2:0], y[5:3], c};
  endfunction

  // Attribute byte: fixed 110 prefix, then cell row and column.
  function automatic logic [VADDR_W-1:0] attr_addr(input logic [ROW_W-1:0] y,
                                                   input logic [COL_W-1:0] c);
    return {3'b110, y[7:6], y[5:3], c};
  endfunction

endpackage

// File: rtl/ctg_raster_pos.sv
module ctg_raster_pos #(
  parameter int LINE_TSTATES = 224,
  parameter int FRAME_LINES  = 312,
  localparam int T_W    = $clog2(LINE_TSTATES),
  localparam int LINE_W = $clog2(FRAME_LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tstate_en,
  input  logic              frame_start,
  output logic [T_W-1:0]    tstate_q,
  output logic [LINE_W-1:0] line_q,
  output logic [T_W-1:0]    tstate_nxt,
  output logic [LINE_W-1:0] line_nxt
);

  localparam logic [T_W-1:0]    T_LAST = T_W'(LINE_TSTATES - 1);
  localparam logic [LINE_W-1:0] L_LAST = LINE_W'(FRAME_LINES - 1);

  logic end_of_line;
  logic end_of_frame;

  assign end_of_line  = (tstate_q == T_LAST);
  assign end_of_frame = end_of_line && (line_q == L_LAST);

  always_comb begin
    tstate_nxt = tstate_q;
    line_nxt   = line_q;
    if (frame_start) begin
      tstate_nxt = '0;
      line_nxt   = '0;
    end else if (tstate_en) begin
      if (end_of_line) begin
        tstate_nxt = '0;
        line_nxt   = end_of_frame ? '0 : line_q + 1'b1;
      end else begin
        tstate_nxt = tstate_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tstate_q <= '0;
      line_q   <= '0;
    end else begin
      tstate_q <= tstate_nxt;
      line_q   <= line_nxt;
    end
  end

endmodule

// File: rtl/ctg_fetch_decode.sv
module ctg_fetch_decode
  import ctg_pkg::*;
#(
  parameter int          LINE_TSTATES   = 224,
  parameter int          ACTIVE_TSTATES = 128,
  parameter int          PICTURE_LINES  = 192,
  parameter int          FRAME_LINES    = 312,
  parameter int          CONTEND_START  = 14336,
  parameter logic [7:0]  STALL_MASK     = 8'b1100_1111,
  localparam int T_W       = $clog2(LINE_TSTATES),
  localparam int LINE_W    = $clog2(FRAME_LINES),
  localparam int ACT_W     = $clog2(ACTIVE_TSTATES),
  localparam int TOP_LINES = CONTEND_START / LINE_TSTATES
) (
  input  logic [T_W-1:0]    tstate,
  input  logic [LINE_W-1:0] line,
  output logic              in_window,
  output ctg_out_t          dec
);

  localparam logic [LINE_W-1:0] FIRST_ROW = LINE_W'(TOP_LINES);
  localparam logic [LINE_W-1:0] END_ROW   = LINE_W'(TOP_LINES + PICTURE_LINES);
  localparam logic [T_W-1:0]    ACT_END   = T_W'(ACTIVE_TSTATES);

  logic [PHASE_W-1:0] phase;
  logic [ACT_W-1:0]   t_act;
  logic [LINE_W-1:0]  row_full;
  logic [ROW_W-1:0]   row;
  logic [COL_W-1:0]   col;
  logic               fetching;

  assign phase    = tstate[PHASE_W-1:0];
  assign t_act    = ACT_W'(tstate);
  assign row_full = line - FIRST_ROW;
  assign row      = ROW_W'(row_full);
  assign col      = {t_act[ACT_W-1:PHASE_W], phase[1]};
  assign in_window = (line >= FIRST_ROW) && (line < END_ROW) && (tstate < ACT_END);
  assign fetching  = in_window && !phase[2];

  always_comb begin
    dec = CTG_IDLE;
    if (in_window) begin
      dec.wait_n = !STALL_MASK[phase];
    end
    if (fetching) begin
      dec.rd_n    = 1'b0;
      dec.is_attr = phase[0];
      dec.addr    = phase[0] ? attr_addr(row, col) : pix_addr(row, col);
    end
  end

endmodule

// File: rtl/ctg_out_reg.sv
module ctg_out_reg
  import ctg_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  ctg_out_t d,
  output ctg_out_t q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= CTG_IDLE;
    else        q <= d;
  end

endmodule

// File: rtl/ctg_contention_gen.sv
module ctg_contention_gen
  import ctg_pkg::*;
#(
  parameter int         LINE_TSTATES   = 224,
  parameter int         ACTIVE_TSTATES = 128,
  parameter int         PICTURE_LINES  = 192,
  parameter int         FRAME_LINES    = 312,
  parameter int         CONTEND_START  = 14336,
  parameter logic [7:0] STALL_MASK     = 8'b1100_1111
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tstate_en,
  input  logic                frame_start,
  output logic                wait_n,
  output logic                rd_n,
  output logic [VADDR_W-1:0]  vaddr,
  output logic                fetch_attr
);

  localparam int T_W    = $clog2(LINE_TSTATES);
  localparam int LINE_W = $clog2(FRAME_LINES);

  logic [T_W-1:0]    tstate_q;
  logic [LINE_W-1:0] line_q;
  logic [T_W-1:0]    tstate_nxt;
  logic [LINE_W-1:0] line_nxt;
  logic              window_nxt;
  ctg_out_t          dec_nxt;
  ctg_out_t          out_q;

  ctg_raster_pos #(
    .LINE_TSTATES (LINE_TSTATES),
    .FRAME_LINES  (FRAME_LINES)
  ) u_pos (
    .clk         (clk),
    .rst_n       (rst_n),
    .tstate_en   (tstate_en),
    .frame_start (frame_start),
    .tstate_q    (tstate_q),
    .line_q      (line_q),
    .tstate_nxt  (tstate_nxt),
    .line_nxt    (line_nxt)
  );

  ctg_fetch_decode #(
    .LINE_TSTATES   (LINE_TSTATES),
    .ACTIVE_TSTATES (ACTIVE_TSTATES),
    .PICTURE_LINES  (PICTURE_LINES),
    .FRAME_LINES    (FRAME_LINES),
    .CONTEND_START  (CONTEND_START),
    .STALL_MASK     (STALL_MASK)
  ) u_dec (
    .tstate    (tstate_nxt),
    .line      (line_nxt),
    .in_window (window_nxt),
    .dec       (dec_nxt)
  );

  ctg_out_reg u_oreg (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (dec_nxt),
    .q     (out_q)
  );

  assign wait_n     = out_q.wait_n;
  assign rd_n       = out_q.rd_n;
  assign vaddr      = out_q.addr;
  assign fetch_attr = out_q.is_attr;

endmodule

// File: rtl/ctg_contention_chk.sv
module ctg_contention_chk #(
  parameter int LINE_TSTATES = 224,
  parameter int FRAME_LINES  = 312,
  parameter int T_W          = 8,
  parameter int LINE_W       = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tstate_en,
  input logic              frame_start,
  input logic              wait_n,
  input logic              rd_n,
  input logic [12:0]       vaddr,
  input logic              fetch_attr,
  input logic [T_W-1:0]    tstate_q,
  input logic [LINE_W-1:0] line_q
);

  // R1
  idle_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_n |-> (vaddr == 13'd0) && !fetch_attr);

  // R2
  frame_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (tstate_q == '0) && (line_q == '0) && wait_n && rd_n);

  // R3
  pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(tstate_q) < LINE_TSTATES) && (32'(line_q) < FRAME_LINES));

  // R6
  read_stalls_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !wait_n);

  // R7
  fetch_pairing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n && !fetch_attr && tstate_en && !frame_start) |=> (!rd_n && fetch_attr));

  // R8
  pix_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n && !fetch_attr) |-> (vaddr[12:11] != 2'b11));

  // R9
  attr_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n && fetch_attr) |-> (vaddr[12:10] == 3'b110));

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tstate_en && !frame_start) |=> $stable(wait_n) && $stable(rd_n) &&
                                      $stable(vaddr) && $stable(tstate_q) && $stable(line_q));

endmodule

bind ctg_contention_gen ctg_contention_chk #(
  .LINE_TSTATES (LINE_TSTATES),
  .FRAME_LINES  (FRAME_LINES),
  .T_W          (T_W),
  .LINE_W       (LINE_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tstate_en   (tstate_en),
  .frame_start (frame_start),
  .wait_n      (wait_n),
  .rd_n        (rd_n),
  .vaddr       (vaddr),
  .fetch_attr  (fetch_attr),
  .tstate_q    (tstate_q),
  .line_q      (line_q)
);

// File: tb/sim_ctg_contention_gen.sv
module sim_ctg_contention_gen;

  localparam int LT     = 224;
  localparam int ACT    = 128;
  localparam int PICL   = 192;
  localparam int FL     = 200;
  localparam int CSTART = 896;
  localparam int TOPL   = CSTART / LT;
  localparam int FRAME_T = FL * LT;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tstate_en = 1'b0;
  logic        frame_start = 1'b0;
  logic        wait_n;
  logic        rd_n;
  logic [12:0] vaddr;
  logic        fetch_attr;

  int n_chk = 0;
  int n_bad = 0;
  int p = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  ctg_contention_gen #(
    .LINE_TSTATES   (LT),
    .ACTIVE_TSTATES (ACT),
    .PICTURE_LINES  (PICL),
    .FRAME_LINES    (FL),
    .CONTEND_START  (CSTART)
  ) u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .tstate_en   (tstate_en),
    .frame_start (frame_start),
    .wait_n      (wait_n),
    .rd_n        (rd_n),
    .vaddr       (vaddr),
    .fetch_attr  (fetch_attr)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s pos=%0d actual=%0d expected=%0d", req, p, act, exp);
    end
  endtask

  task automatic compare_model(input bit held);
    int line, t, ph, y, col, ew, er, ea, ead;
    bit inw;
    line = p / LT;
    t    = p % LT;
    ph   = t % 8;
    inw  = (line >= TOPL) && (line < TOPL + PICL) && (t < ACT);
    y    = line - TOPL;
    col  = (t / 8) * 2 + (ph / 2);
    ew = 1; er = 1; ea = 0; ead = 0;
    if (inw) begin
      ew = (ph == 4 || ph == 5) ? 1 : 0;
      if (ph < 4) begin
        er = 0;
        ea = ph % 2;
        if (ea == 1) ead = (6 << 10) + ((y / 64) << 8) + (((y / 8) % 8) << 5) + col;
        else         ead = ((y / 64) << 11) + ((y % 8) << 8) + (((y / 8) % 8) << 5) + col;
      end
    end
    if (held) begin
      check("R10 wait_n", int'(wait_n), ew);
      check("R10 vaddr", int'(vaddr), ead);
    end else if (!inw) begin
      check("R4 wait_n", int'(wait_n), ew);
      check("R4 rd_n", int'(rd_n), er);
      check("R4 vaddr", int'(vaddr), ead);
    end else begin
      check("R5 wait_n", int'(wait_n), ew);
      check("R6 rd_n", int'(rd_n), er);
      check("R7 fetch_attr", int'(fetch_attr), ea);
      if (ea == 1) check("R9 vaddr", int'(vaddr), ead);
      else         check("R8 vaddr", int'(vaddr), ead);
    end
  endtask

  // Called at a falling edge; drives, waits one rising edge, samples at the next fall.
  task automatic tick(input bit en);
    tstate_en = en;
    @(posedge clk);
    if (en) p = (p + 1) % FRAME_T;
    @(negedge clk);
    compare_model(!en);
  endtask

  task automatic pulse_frame(input bit en);
    frame_start = 1'b1;
    tstate_en = en;
    @(posedge clk);
    p = 0;
    @(negedge clk);
    frame_start = 1'b0;
    check("R2 wait_n", int'(wait_n), 1);
    check("R2 rd_n", int'(rd_n), 1);
    compare_model(1'b0);
  endtask

  initial begin
    @(negedge clk);
    check("R1 wait_n", int'(wait_n), 1);
    check("R1 rd_n", int'(rd_n), 1);
    check("R1 fetch_attr", int'(fetch_attr), 0);
    check("R1 vaddr", int'(vaddr), 0);
    rst_n = 1'b1;
    @(negedge clk);
    compare_model(1'b0);

    pulse_frame(1'b0);
    // Full frame, wrap, and into the next frame's picture area.
    for (int i = 0; i < FRAME_T + CSTART + 300; i++) begin
      tick(1'b1);
      if (p == CSTART - 1) check("R11 border before first stall", int'(wait_n), 1);
      if (p == CSTART)     check("R11 first stall", int'(wait_n), 0);
      if (i == FRAME_T - 1) check("R3 wrapped to origin", p, 0);
      if (i >= FRAME_T && p == CSTART) check("R3 stall after wrap", int'(wait_n), 0);
    end

    // Frame start in the middle of a picture line, with enable high.
    for (int i = 0; i < 37; i++) tick(1'b1);
    pulse_frame(1'b1);

    // Sparse enables from origin into the picture.
    for (int i = 0; i < 3300; i++) tick(i % 3 == 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule